// File: doc/BRIEF.md
# Byte Stream Reader and Punch Controller

This block sits between a processor's I/O strobe and two byte channels: an input channel that pulls bytes from a source, and an output channel that pushes bytes to a sink. Each channel owns an 8-bit buffer and a done flag. On each strobe the block compares the device code with the two channel codes and decodes the 4-bit operation. It then updates the flags, starts transfers, merges reader data into a 32-bit accumulator image, or raises a skip request.

The transfers finish whenever the far side responds. The reader holds `src_ready` high until a byte arrives. The punch holds `snk_valid` and its data steady until the sink takes the byte. The processor polls the flags with the skip operations. Results return one cycle after the strobe, on registered outputs: a write enable with the new accumulator value, and a skip pulse.

Top module: `byte_io_ctrl`

## Requirements
- R1: After reset both done flags are 0, `src_ready`, `snk_valid`, `acc_we` and `skip` are 0, and no transfer is outstanding.
- R2: Only a strobe with device code 0x01 (reader) or 0x02 (punch) and operation code 1, 2, 4 or 6 has any effect. Every other device code or operation code changes no flag, buffer, handshake, accumulator or skip output.
- R3: Reader operation 1 gives `skip`=1 in the cycle after the strobe exactly when the reader flag is 1.
- R4: Reader operation 4 clears the reader flag and raises `src_ready`. When `src_valid` and `src_ready` are both high on a clock edge, the byte enters the reader buffer, the flag becomes 1 and `src_ready` drops.
- R5: Reader operation 2 gives, one cycle after the strobe, `acc_we`=1 and `acc_out` = `acc_in` OR the zero-extended reader buffer, so bits 31..8 pass through unchanged. It also sets the reader flag to 1.
- R6: Reader operation 6 performs the OR merge of R5, clears the reader flag and starts a new fetch as in R4.
- R7: Punch operation 1 gives `skip`=1 in the cycle after the strobe exactly when the punch flag is 1. Punch operation 2 clears the punch flag.
- R8: Punch operation 4 loads the punch buffer from `acc_in[7:0]` and raises `snk_valid` with that byte on `snk_data`. It leaves the flag as it was. The flag becomes 1 on the edge where `snk_valid` and `snk_ready` are both high, and `snk_valid` then drops.
- R9: Punch operation 6 clears the punch flag and then loads and starts a write as in R8.
- R10: A punch operation 4 or 6 issued while a write is still outstanding neither reloads the buffer nor starts a second write. The flag clear of operation 6 still applies.
- R11: `src_ready` stays high until a byte is accepted. `snk_valid` stays high and `snk_data` stays constant until the sink accepts.
- R12: `acc_we` and `skip` are registered one-cycle pulses that appear only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | One-cycle I/O command strobe |
| io_dev | input | 8 | Device code of the command |
| io_op | input | 4 | Operation code of the command |
| acc_in | input | 32 | Current accumulator value |
| acc_out | output | 32 | New accumulator value, valid when acc_we is high |
| acc_we | output | 1 | Accumulator write pulse |
| skip | output | 1 | Skip request pulse |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | 8 | Byte from the source |
| src_ready | output | 1 | Reader is waiting for a byte |
| snk_valid | output | 1 | Punch offers a byte |
| snk_data | output | 8 | Byte to the sink |
| snk_ready | input | 1 | Sink takes the byte |

## Verification
The flags and buffers are internal, so a wrong state shows up through the skip operations and the handshake pins. A flag that is wrong appears on `skip` in the cycle after the next poll. A wrong reader buffer appears in the low byte of `acc_out` on the next merge, and a wrong punch buffer appears on `snk_data` as soon as the write starts. Each fault is therefore visible within one command plus one cycle. The bench also stalls both channels so that a dropped hold or a reload during a stall shows on the pins while the stall lasts.

// File: rtl/byte_io_pkg.sv
package byte_io_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_POLL = 4'd1;
  localparam logic [OPC_W-1:0] OPC_TWO  = 4'd2;
  localparam logic [OPC_W-1:0] OPC_GO   = 4'd4;
  localparam logic [OPC_W-1:0] OPC_BOTH = 4'd6;

  typedef struct packed {
    logic poll;
    logic two;
    logic go;
    logic both;
  } chan_cmd_t;
endpackage

// File: rtl/byte_io_decode.sv
module byte_io_decode
  import byte_io_pkg::*;
#(
  parameter int DEV_W = 8,
  parameter logic [DEV_W-1:0] RD_DEV = 8'h01,
  parameter logic [DEV_W-1:0] PU_DEV = 8'h02
) (
  input  logic             strobe,
  input  logic [DEV_W-1:0] dev,
  input  logic [OPC_W-1:0] op,
  output chan_cmd_t        rd_cmd,
  output chan_cmd_t        pu_cmd
);
  chan_cmd_t any_cmd;

  always_comb begin
    any_cmd.poll = (op == OPC_POLL);
    any_cmd.two  = (op == OPC_TWO);
    any_cmd.go   = (op == OPC_GO);
    any_cmd.both = (op == OPC_BOTH);
  end

  assign rd_cmd = (strobe && dev == RD_DEV) ? any_cmd : '0;
  assign pu_cmd = (strobe && dev == PU_DEV) ? any_cmd : '0;
endmodule

// File: rtl/byte_rd_chan.sv
module byte_rd_chan #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_fill,
  input  logic              cmd_go,
  input  logic              cmd_both,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              src_ready,
  output logic              flag,
  output logic [BYTE_W-1:0] held
);
  logic take;
  assign take = src_valid && src_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_ready <= 1'b0;
      flag      <= 1'b0;
      held      <= '0;
    end else begin
      if (take) begin
        held      <= src_data;
        src_ready <= 1'b0;
        flag      <= 1'b1;
      end
      if (cmd_go || cmd_both) begin
        flag      <= 1'b0;
        src_ready <= 1'b1;
      end
      if (cmd_fill) flag <= 1'b1;
    end
  end

  assert_ready_hold_R11: assert property (@(posedge clk) disable iff (rst)
    src_ready && !src_valid |=> src_ready);

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> ($past(take) || $past(cmd_fill)));
endmodule

// File: rtl/byte_pu_chan.sv
module byte_pu_chan #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_clr,
  input  logic              cmd_go,
  input  logic              cmd_both,
  input  logic [BYTE_W-1:0] load_val,
  output logic              snk_valid,
  output logic [BYTE_W-1:0] snk_data,
  input  logic              snk_ready,
  output logic              flag
);
  logic busy;
  assign busy = snk_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      snk_valid <= 1'b0;
      snk_data  <= '0;
      flag      <= 1'b0;
    end else begin
      if (snk_valid && snk_ready) begin
        snk_valid <= 1'b0;
        flag      <= 1'b1;
      end
      if (cmd_clr || cmd_both) flag <= 1'b0;
      if ((cmd_go || cmd_both) && !busy) begin
        snk_data  <= load_val;
        snk_valid <= 1'b1;
      end
    end
  end

  assert_valid_hold_R11: assert property (@(posedge clk) disable iff (rst)
    snk_valid && !snk_ready |=> snk_valid && $stable(snk_data));

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    snk_valid && (cmd_go || cmd_both) |=> $stable(snk_data));
endmodule

// File: rtl/byte_io_ctrl.sv
module byte_io_ctrl
  import byte_io_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int BYTE_W = 8,
  parameter int DEV_W  = 8,
  parameter logic [DEV_W-1:0] RD_DEV = 8'h01,
  parameter logic [DEV_W-1:0] PU_DEV = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_strobe,
  input  logic [DEV_W-1:0]  io_dev,
  input  logic [OPC_W-1:0]  io_op,
  input  logic [ACC_W-1:0]  acc_in,
  output logic [ACC_W-1:0]  acc_out,
  output logic              acc_we,
  output logic              skip,
  input  logic              src_valid,
  input  logic [BYTE_W-1:0] src_data,
  output logic              src_ready,
  output logic              snk_valid,
  output logic [BYTE_W-1:0] snk_data,
  input  logic              snk_ready
);
  localparam int PAD_W = ACC_W - BYTE_W;

  chan_cmd_t         rd_cmd, pu_cmd;
  logic              rd_flag, pu_flag;
  logic [BYTE_W-1:0] rd_held;

  byte_io_decode #(.DEV_W(DEV_W), .RD_DEV(RD_DEV), .PU_DEV(PU_DEV)) u_dec (
    .strobe(io_strobe), .dev(io_dev), .op(io_op),
    .rd_cmd(rd_cmd), .pu_cmd(pu_cmd)
  );

  byte_rd_chan #(.BYTE_W(BYTE_W)) u_rd (
    .clk(clk), .rst(rst),
    .cmd_fill(rd_cmd.two), .cmd_go(rd_cmd.go), .cmd_both(rd_cmd.both),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .flag(rd_flag), .held(rd_held)
  );

  byte_pu_chan #(.BYTE_W(BYTE_W)) u_pu (
    .clk(clk), .rst(rst),
    .cmd_clr(pu_cmd.two), .cmd_go(pu_cmd.go), .cmd_both(pu_cmd.both),
    .load_val(acc_in[BYTE_W-1:0]),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready),
    .flag(pu_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      acc_we  <= 1'b0;
      skip    <= 1'b0;
    end else begin
      acc_out <= acc_in | {{PAD_W{1'b0}}, rd_held};
      acc_we  <= rd_cmd.two || rd_cmd.both;
      skip    <= (rd_cmd.poll && rd_flag) || (pu_cmd.poll && pu_flag);
    end
  end

  assert_upper_keep_R5: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> acc_out[ACC_W-1:BYTE_W] == $past(acc_in[ACC_W-1:BYTE_W]));

  assert_pulse_after_strobe_R12: assert property (@(posedge clk) disable iff (rst)
    (skip || acc_we) |-> $past(io_strobe));
endmodule

// File: tb/byte_io_ctrl_test.sv
`timescale 1ns/1ps
module byte_io_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_strobe = 1'b0;
  logic [7:0]  io_dev = '0;
  logic [3:0]  io_op = '0;
  logic [31:0] acc_in = '0;
  logic [31:0] acc_out;
  logic        acc_we, skip;
  logic        src_valid = 1'b0;
  logic [7:0]  src_data = '0;
  logic        src_ready;
  logic        snk_valid;
  logic [7:0]  snk_data;
  logic        snk_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic        q_we[$];
  logic [31:0] q_acc[$];
  logic        q_sk[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  byte_io_ctrl uut (
    .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_dev(io_dev), .io_op(io_op),
    .acc_in(acc_in), .acc_out(acc_out), .acc_we(acc_we), .skip(skip),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares registered results against the scoreboard queue
  always @(negedge clk) begin
    if (q_we.size() > 0) begin
      logic e_we, e_sk;
      logic [31:0] e_acc;
      string t;
      e_we = q_we.pop_front();
      e_acc = q_acc.pop_front();
      e_sk = q_sk.pop_front();
      t = q_tag.pop_front();
      chk({t, " acc_we"}, {31'b0, acc_we}, {31'b0, e_we});
      chk({t, " skip"}, {31'b0, skip}, {31'b0, e_sk});
      if (e_we) chk({t, " acc_out"}, acc_out, e_acc);
    end
  end

  task automatic issue(input logic [7:0] dev, input logic [3:0] op, input logic [31:0] acc,
                       input logic e_we, input logic [31:0] e_acc, input logic e_sk,
                       input string tag);
    @(negedge clk);
    io_strobe = 1'b1; io_dev = dev; io_op = op; acc_in = acc;
    @(posedge clk); #2;
    io_strobe = 1'b0;
    q_we.push_back(e_we); q_acc.push_back(e_acc);
    q_sk.push_back(e_sk); q_tag.push_back(tag);
  endtask

  task automatic feed(input logic [7:0] b);
    @(negedge clk);
    src_valid = 1'b1; src_data = b;
    @(posedge clk); #2;
    src_valid = 1'b0;
  endtask

  task automatic accept;
    @(negedge clk);
    snk_ready = 1'b1;
    @(posedge clk); #2;
    snk_ready = 1'b0;
  endtask

  task automatic pins(input string tag, input logic e_rdy, input logic e_val);
    @(negedge clk);
    chk({tag, " src_ready"}, {31'b0, src_ready}, {31'b0, e_rdy});
    chk({tag, " snk_valid"}, {31'b0, snk_valid}, {31'b0, e_val});
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    // R1: reset state
    pins("R1", 1'b0, 1'b0);
    chk("R1 acc_we", {31'b0, acc_we}, 32'd0);
    chk("R1 skip", {31'b0, skip}, 32'd0);
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R1 reader flag");
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R1 punch flag");

    // R4 fetch
    issue(8'h01, 4'd4, 32'h0, 1'b0, 32'h0, 1'b0, "R4 start");
    pins("R4 waiting", 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    pins("R11 ready held", 1'b1, 1'b0);
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R3 flag low while fetching");
    feed(8'hA5);
    pins("R4 accepted", 1'b0, 1'b0);
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R3 R4 flag set");

    // R5 merge
    issue(8'h01, 4'd2, 32'h1234_5600, 1'b1, 32'h1234_56A5, 1'b0, "R5 merge");
    issue(8'h01, 4'd2, 32'h8000_005A, 1'b1, 32'h8000_00FF, 1'b0, "R5 merge overlap");
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R5 flag set");

    // R6 merge and fetch
    issue(8'h01, 4'd6, 32'hFFFF_0F00, 1'b1, 32'hFFFF_0FA5, 1'b0, "R6 merge");
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R6 flag cleared");
    pins("R6 fetch", 1'b1, 1'b0);
    feed(8'h3C);
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R6 byte arrived");
    issue(8'h01, 4'd2, 32'h0, 1'b1, 32'h0000_003C, 1'b0, "R6 new byte");

    // R2 ignored commands
    issue(8'h03, 4'd2, 32'h0, 1'b0, 32'h0, 1'b0, "R2 other device");
    issue(8'h01, 4'd3, 32'h0, 1'b0, 32'h0, 1'b0, "R2 op3");
    issue(8'h01, 4'd5, 32'h0, 1'b0, 32'h0, 1'b0, "R2 op5");
    issue(8'h01, 4'd7, 32'h0, 1'b0, 32'h0, 1'b0, "R2 op7");
    issue(8'h01, 4'd15, 32'h0, 1'b0, 32'h0, 1'b0, "R2 op15");
    issue(8'h81, 4'd4, 32'h0, 1'b0, 32'h0, 1'b0, "R2 near device");
    issue(8'h02, 4'd0, 32'h55, 1'b0, 32'h0, 1'b0, "R2 punch op0");
    issue(8'h02, 4'd3, 32'h55, 1'b0, 32'h0, 1'b0, "R2 punch op3");
    pins("R2 no handshake", 1'b0, 1'b0);
    issue(8'h01, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R2 reader flag kept");
    issue(8'h01, 4'd2, 32'h0, 1'b1, 32'h0000_003C, 1'b0, "R2 reader buffer kept");

    // R8 punch write
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R7 punch flag low");
    issue(8'h02, 4'd4, 32'hABCD_EF5A, 1'b0, 32'h0, 1'b0, "R8 load");
    pins("R8 offer", 1'b0, 1'b1);
    chk("R8 data", {24'b0, snk_data}, 32'h5A);
    issue(8'h02, 4'd4, 32'h0000_0077, 1'b0, 32'h0, 1'b0, "R10 second load");
    repeat (2) @(negedge clk);
    pins("R11 valid held", 1'b0, 1'b1);
    chk("R10 data kept", {24'b0, snk_data}, 32'h5A);
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R8 flag low while busy");
    accept();
    pins("R8 accepted", 1'b0, 1'b0);
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R7 R8 flag set");
    issue(8'h02, 4'd4, 32'h0000_0011, 1'b0, 32'h0, 1'b0, "R8 load keeps flag");
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R8 flag unchanged on start");
    chk("R10 fresh load after idle", {24'b0, snk_data}, 32'h11);
    accept();
    issue(8'h02, 4'd2, 32'h0, 1'b0, 32'h0, 1'b0, "R7 clear");
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R7 flag cleared");

    // R9 clear and write
    issue(8'h02, 4'd4, 32'h0000_0022, 1'b0, 32'h0, 1'b0, "R9 prep");
    accept();
    issue(8'h02, 4'd6, 32'hFFFF_FFC3, 1'b0, 32'h0, 1'b0, "R9 load");
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b0, "R9 flag cleared");
    pins("R9 offer", 1'b0, 1'b1);
    chk("R9 data", {24'b0, snk_data}, 32'hC3);
    accept();
    issue(8'h02, 4'd1, 32'h0, 1'b0, 32'h0, 1'b1, "R9 done");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule